// File: doc/BRIEF.md
# ALU Operation Select Decoder

This block turns two pieces of information into the 4-bit operation select of a 32-bit ALU. The first is a 2-bit operation class that the main instruction control hands down. The second is the 6-bit function field of a register-format instruction. Memory accesses and conditional branches carry a fixed operation, so the class alone decides their select. Register arithmetic carries its operation in the function field, so the block decodes that field.

The select is produced combinationally, so it is valid in the same cycle its inputs change. A copy of the select, delayed by one clock, is also offered for timing studies and for paths that need a register. Any class or function code that has no defined meaning yields the add select. No latch is inferred for these cases.

The select encoding is fixed and not sequential: AND is 0000, OR is 0001, add is 0010, subtract is 0110 and set-on-less-than is 0111. The code 1100 (NOR) belongs to the same encoding, but no input combination produces it.

Top module: `alu_ctl_decoder`

## Requirements
- R1: With op_class 00 (memory access), alu_sel is 0010 (add) for every funct value.
- R2: With op_class 01 (branch on equal), alu_sel is 0110 (subtract) for every funct value.
- R3: With op_class 10 and funct 100000, alu_sel is 0010 (add).
- R4: With op_class 10 and funct 100010, alu_sel is 0110 (subtract).
- R5: With op_class 10 and funct 100100, alu_sel is 0000 (AND).
- R6: With op_class 10 and funct 100101, alu_sel is 0001 (OR).
- R7: With op_class 10 and funct 101010, alu_sel is 0111 (set-on-less-than).
- R8: With op_class 10 and any other funct value, alu_sel is 0010 (add).
- R9: With op_class 11 (unused), alu_sel is 0010 (add) for every funct value.
- R10: alu_sel follows its inputs within the same cycle, with no clock edge between an input change and the new select.
- R11: alu_sel_q is 0010 while rst_n is low. After each rising clk edge outside reset, it holds the alu_sel value from just before that edge.
- R12: alu_sel only ever takes one of the values 0000, 0001, 0010, 0110 or 0111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy of the select |
| rst_n | input | 1 | Active-low asynchronous reset of the registered copy |
| op_class | input | 2 | Operation class from the main control: 00 memory, 01 branch, 10 register arithmetic, 11 unused |
| funct | input | 6 | Function field of a register-format instruction |
| alu_sel | output | 4 | Combinational ALU operation select |
| alu_sel_q | output | 4 | alu_sel delayed by one clock |

## Verification
On every clock, the assertions check the fixed selects for the memory, branch and unused classes. They also check that each listed function code maps to its operation, that the select never leaves the legal set, and that the registered copy lags the combinational select by exactly one edge. Two things only the bench's full sweep can show. First, every one of the 256 class and function pairs lands on the right select, including the unlisted function codes that fall back to add. Second, the select settles between clock edges, with no edge needed.

// File: rtl/aluctl_pkg.sv
package aluctl_pkg;
    localparam int CLASS_W = 2;
    localparam int FUNCT_W = 6;
    localparam int SEL_W   = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND = 4'b0000,
        SEL_OR  = 4'b0001,
        SEL_ADD = 4'b0010,
        SEL_SUB = 4'b0110,
        SEL_SLT = 4'b0111,
        SEL_NOR = 4'b1100
    } alu_sel_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEM = 2'b00,
        CLS_BEQ = 2'b01,
        CLS_REG = 2'b10,
        CLS_RSV = 2'b11
    } op_class_e;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    typedef struct packed {
        alu_sel_e sel;
    } sel_stage_t;
endpackage

// File: rtl/aluctl_funct_dec.sv
module aluctl_funct_dec
    import aluctl_pkg::*;
(
    input  logic [FUNCT_W-1:0] funct,
    output alu_sel_e           fn_sel
);
    always_comb begin
        case (funct)
            FN_ADD:  fn_sel = SEL_ADD;
            FN_SUB:  fn_sel = SEL_SUB;
            FN_AND:  fn_sel = SEL_AND;
            FN_OR:   fn_sel = SEL_OR;
            FN_SLT:  fn_sel = SEL_SLT;
            default: fn_sel = SEL_ADD;
        endcase
    end
endmodule

// File: rtl/aluctl_class_mux.sv
module aluctl_class_mux
    import aluctl_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  alu_sel_e           fn_sel,
    output alu_sel_e           sel
);
    always_comb begin
        case (op_class_e'(op_class))
            CLS_MEM: sel = SEL_ADD;
            CLS_BEQ: sel = SEL_SUB;
            CLS_REG: sel = fn_sel;
            default: sel = SEL_ADD;
        endcase
    end
endmodule

// File: rtl/aluctl_sel_reg.sv
module aluctl_sel_reg
    import aluctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  alu_sel_e sel_in,
    output alu_sel_e sel_out
);
    sel_stage_t stage_d;
    sel_stage_t stage_q;

    always_comb begin
        stage_d     = stage_q;
        stage_d.sel = sel_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '{sel: SEL_ADD};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sel_out = stage_q.sel;
endmodule

// File: rtl/alu_ctl_decoder.sv
module alu_ctl_decoder
    import aluctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNCT_W-1:0] funct,
    output logic [SEL_W-1:0]   alu_sel,
    output logic [SEL_W-1:0]   alu_sel_q
);
    alu_sel_e fn_sel;
    alu_sel_e comb_sel;
    alu_sel_e reg_sel;

    aluctl_funct_dec u_funct_dec (
        .funct  (funct),
        .fn_sel (fn_sel)
    );

    aluctl_class_mux u_class_mux (
        .op_class (op_class),
        .fn_sel   (fn_sel),
        .sel      (comb_sel)
    );

    aluctl_sel_reg u_sel_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_in  (comb_sel),
        .sel_out (reg_sel)
    );

    assign alu_sel   = comb_sel;
    assign alu_sel_q = reg_sel;
endmodule

// File: rtl/aluctl_checker.sv
module aluctl_checker
    import aluctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [CLASS_W-1:0] op_class,
    input logic [FUNCT_W-1:0] funct,
    input logic [SEL_W-1:0]   alu_sel,
    input logic [SEL_W-1:0]   alu_sel_q
);
    AST_MEM_FORCES_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 2'b00 |-> alu_sel == 4'b0010); // R1
    AST_BEQ_FORCES_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 2'b01 |-> alu_sel == 4'b0110); // R2
    AST_FN_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b10 && funct == 6'b100000) |-> alu_sel == 4'b0010); // R3
    AST_FN_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b10 && funct == 6'b100010) |-> alu_sel == 4'b0110); // R4
    AST_FN_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b10 && funct == 6'b100100) |-> alu_sel == 4'b0000); // R5
    AST_FN_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b10 && funct == 6'b100101) |-> alu_sel == 4'b0001); // R6
    AST_FN_SLT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b10 && funct == 6'b101010) |-> alu_sel == 4'b0111); // R7
    AST_RSV_DEFAULT_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 2'b11 |-> alu_sel == 4'b0010); // R9
    AST_REG_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> alu_sel_q == $past(alu_sel)); // R11
    AST_LEGAL_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        alu_sel inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111}); // R12
endmodule

bind alu_ctl_decoder aluctl_checker u_aluctl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_class  (op_class),
    .funct     (funct),
    .alu_sel   (alu_sel),
    .alu_sel_q (alu_sel_q)
);

// File: tb/alu_ctl_decoder_bench.sv
module alu_ctl_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_class = 2'b00;
    logic [5:0] funct = 6'b000000;
    logic [3:0] alu_sel;
    logic [3:0] alu_sel_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_ctl_decoder u_alu_ctl_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_class  (op_class),
        .funct     (funct),
        .alu_sel   (alu_sel),
        .alu_sel_q (alu_sel_q)
    );

    function automatic logic [3:0] expect_sel(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'd0) return 4'd2;
        if (c == 2'd1) return 4'd6;
        if (c == 2'd3) return 4'd2;
        if (f == 6'd32) return 4'd2;
        if (f == 6'd34) return 4'd6;
        if (f == 6'd36) return 4'd0;
        if (f == 6'd37) return 4'd1;
        if (f == 6'd42) return 4'd7;
        return 4'd2;
    endfunction

    function automatic string req_of(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'd0) return "R1";
        if (c == 2'd1) return "R2";
        if (c == 2'd3) return "R9";
        if (f == 6'd32) return "R3";
        if (f == 6'd34) return "R4";
        if (f == 6'd36) return "R5";
        if (f == 6'd37) return "R6";
        if (f == 6'd42) return "R7";
        return "R8";
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (class=%b funct=%b)",
                     req, act, exp, op_class, funct);
        end
    endtask

    initial begin
        logic [3:0] prev_exp;
        bit         have_prev;
        bit         legal;
        have_prev = 1'b0;
        prev_exp  = 4'd0;
        repeat (3) @(negedge clk);
        check("R11", alu_sel_q, 4'b0010);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 64; f++) begin
                @(negedge clk);
                if (have_prev) check("R11", alu_sel_q, prev_exp);
                op_class = 2'(c);
                funct    = 6'(f);
                #1;
                check(req_of(2'(c), 6'(f)), alu_sel, expect_sel(2'(c), 6'(f)));
                legal = (alu_sel == 4'd0) || (alu_sel == 4'd1) || (alu_sel == 4'd2) ||
                        (alu_sel == 4'd6) || (alu_sel == 4'd7);
                check("R12", {3'b000, legal}, 4'd1);
                prev_exp  = expect_sel(2'(c), 6'(f));
                have_prev = 1'b1;
            end
        end
        // R10: several changes between two edges, each seen without a clock edge
        @(posedge clk);
        #1;
        op_class = 2'b10; funct = 6'b100100; #1;
        check("R10", alu_sel, 4'b0000);
        funct = 6'b101010; #1;
        check("R10", alu_sel, 4'b0111);
        op_class = 2'b01; #1;
        check("R10", alu_sel, 4'b0110);
        // R11: reset returns the registered copy to add
        @(negedge clk);
        op_class = 2'b10; funct = 6'b100101;
        @(negedge clk);
        check("R11", alu_sel_q, 4'b0001);
        rst_n = 1'b0; #1;
        check("R11", alu_sel_q, 4'b0010);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule